// File: doc/BRIEF.md
# Crypto Job Length Tracker

This block keeps the byte-length context of a block-cipher job and decides when the job starts and when it ends. A host programs three 32-bit words: the low and high halves of a payload length and an associated-data length. Depending on the operating mode, one of these writes launches the job. While the job runs, the block tells the cipher datapath how many bytes the current 16-byte block holds and whether it is the final block of the job. Each time the datapath consumes a block, the block reduces the matching remaining count.

Associated data is processed first, then payload. A one-cycle done pulse marks the end of the job. In the plain streaming modes a zero payload length means the stream has no end. In XTS mode the associated-data word carries a block index instead of a length. Host reads of the length words always return zero.

Top module: `crypto_len_tracker`

## Requirements
- R1: After reset, start_o, busy_o, done_o, last_o and blk_is_aad_o are low and blk_bytes_o is 0.
- R2: In modes STREAM (mode_i=0), XTS (2) and FIXED (3), a host write to the payload-high word (wr_sel_i=1) gives a one-cycle start_o pulse in the cycle after the write. busy_o rises one cycle after start_o. A payload-low write (wr_sel_i=0) never starts a job.
- R3: Only bits [28:0] of the payload-high word are kept. The payload length is {hi[28:0], lo[31:0]} bytes, and bits [31:29] of the high word have no effect.
- R4: In mode AEAD (mode_i=1), a write to the associated-data word (wr_sel_i=2) starts the job with the same timing as R2. A payload-high write does not start it.
- R5: While busy, blk_bytes_o equals the lesser of 16 and the bytes remaining in the current phase. Associated data comes first, with blk_is_aad_o high, and payload follows. Each block is consumed on a clock edge where blk_req_i is high. last_o is high exactly during the final block of the job.
- R6: done_o is high for exactly one cycle, in the cycle after the final block is consumed, and busy_o is low from that cycle on.
- R7: In STREAM mode a zero payload length starts an endless job. Every block reports 16 bytes, and last_o and done_o stay low.
- R8: A write that would start a job with no data gives no start. This covers a zero payload in XTS or FIXED, and both lengths zero in AEAD. In AEAD either length alone may be zero.
- R9: In XTS mode, an associated-data write stores wr_data_i[31:4] on xts_index_o and does not start a job.
- R10: rd_data_o reads zero at all times, whatever has been written.
- R11: When no job is running, blk_req_i has no effect: busy_o, done_o and last_o stay low and blk_bytes_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Word select: 0 payload low, 1 payload high, 2 associated data / index, 3 none |
| wr_data_i | input | 32 | Host write data |
| mode_i | input | 2 | Mode: 0 STREAM, 1 AEAD, 2 XTS, 3 FIXED |
| blk_req_i | input | 1 | Datapath consumes the current block |
| rd_data_o | output | 32 | Host read data of the length words (always zero) |
| start_o | output | 1 | One-cycle job start pulse |
| busy_o | output | 1 | Job in progress |
| blk_bytes_o | output | 5 | Valid bytes in the current block |
| blk_is_aad_o | output | 1 | Current block is associated data |
| last_o | output | 1 | Current block is the last of the job |
| done_o | output | 1 | One-cycle job completion pulse |
| xts_index_o | output | 28 | Stored XTS block index |

## Verification
A wrong remaining count first shows up at blk_bytes_o, on the first block after the fault. A count that drifts by whole blocks shows up later, as last_o and done_o arriving one or more blocks too early or too late. A wrong phase flag swaps blk_is_aad_o and the byte counts at the boundary between associated data and payload. A wrong endless-stream flag makes a STREAM job with zero length report a final block, or makes a finite job never end. Faults in the trigger logic show within one cycle of the host write, as a missing or extra start_o.

// File: rtl/crypto_len_pkg.sv
package crypto_len_pkg;
  typedef enum logic [1:0] {
    MODE_STREAM = 2'd0,
    MODE_AEAD   = 2'd1,
    MODE_XTS    = 2'd2,
    MODE_FIXED  = 2'd3
  } cl_mode_e;

  typedef enum logic [1:0] {
    SEL_PAY_LO = 2'd0,
    SEL_PAY_HI = 2'd1,
    SEL_AAD    = 2'd2,
    SEL_NONE   = 2'd3
  } cl_sel_e;
endpackage

// File: rtl/cl_host_regs.sv
module cl_host_regs
  import crypto_len_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int HI_KEEP = 29,
  parameter int IDX_LSB = 4,
  localparam int PAY_W  = WORD_W + HI_KEEP,
  localparam int IDX_W  = WORD_W - IDX_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  cl_sel_e           wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  cl_mode_e          mode_i,
  output logic              start_o,
  output cl_mode_e          mode_o,
  output logic [PAY_W-1:0]  pay_len_o,
  output logic [WORD_W-1:0] aad_len_o,
  output logic [IDX_W-1:0]  xts_idx_o
);
  logic [WORD_W-1:0]  pay_lo_q;
  logic [HI_KEEP-1:0] pay_hi_q;
  logic [WORD_W-1:0]  aad_q;
  logic [IDX_W-1:0]   idx_q;
  cl_mode_e           mode_q;
  logic               start_q;

  logic lo_en, hi_en, aad_en, idx_en, start_d;
  logic [PAY_W-1:0] hi_len_new;

  always_comb begin
    hi_len_new = {wr_data_i[HI_KEEP-1:0], pay_lo_q};
    lo_en  = wr_en_i && (wr_sel_i == SEL_PAY_LO);
    hi_en  = wr_en_i && (wr_sel_i == SEL_PAY_HI);
    aad_en = wr_en_i && (wr_sel_i == SEL_AAD) && (mode_i != MODE_XTS);
    idx_en = wr_en_i && (wr_sel_i == SEL_AAD) && (mode_i == MODE_XTS);
    start_d = 1'b0;
    if (hi_en && (mode_i != MODE_AEAD))
      start_d = (mode_i == MODE_STREAM) || (hi_len_new != '0);
    if (aad_en && (mode_i == MODE_AEAD))
      start_d = (wr_data_i != '0) || ({pay_hi_q, pay_lo_q} != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_lo_q <= '0;
      pay_hi_q <= '0;
      aad_q    <= '0;
      idx_q    <= '0;
      mode_q   <= MODE_STREAM;
      start_q  <= 1'b0;
    end else begin
      if (lo_en)   pay_lo_q <= wr_data_i;
      if (hi_en)   pay_hi_q <= wr_data_i[HI_KEEP-1:0];
      if (aad_en)  aad_q    <= wr_data_i;
      if (idx_en)  idx_q    <= wr_data_i[WORD_W-1:IDX_LSB];
      if (start_d) mode_q   <= mode_i;
      start_q <= start_d;
    end
  end

  assign start_o   = start_q;
  assign mode_o    = mode_q;
  assign pay_len_o = {pay_hi_q, pay_lo_q};
  assign aad_len_o = aad_q;
  assign xts_idx_o = idx_q;
endmodule

// File: rtl/cl_blk_counter.sv
module cl_blk_counter #(
  parameter int W   = 32,
  parameter int BLK = 16,
  localparam int BW = $clog2(BLK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [W-1:0]  load_val_i,
  input  logic          step_i,
  output logic          zero_o,
  output logic          last_o,
  output logic [BW-1:0] bytes_o
);
  logic [W-1:0]  rem_q, rem_d;
  logic [BW-1:0] bytes;
  logic          full;

  always_comb begin
    full  = (rem_q >= W'(BLK));
    bytes = full ? BW'(BLK) : rem_q[BW-1:0];
    rem_d = rem_q;
    if (load_i)      rem_d = load_val_i;
    else if (step_i) rem_d = rem_q - W'(bytes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else if (load_i || step_i) rem_q <= rem_d;
  end

  assign zero_o  = (rem_q == '0);
  assign last_o  = !zero_o && (rem_q <= W'(BLK));
  assign bytes_o = bytes;
endmodule

// File: rtl/cl_job_seq.sv
module cl_job_seq #(
  parameter int BLK = 16,
  localparam int BW = $clog2(BLK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          load_inf_i,
  input  logic          blk_req_i,
  input  logic          aad_zero_i,
  input  logic          aad_last_i,
  input  logic [BW-1:0] aad_bytes_i,
  input  logic          pay_zero_i,
  input  logic          pay_last_i,
  input  logic [BW-1:0] pay_bytes_i,
  output logic          aad_step_o,
  output logic          pay_step_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          last_o,
  output logic          is_aad_o,
  output logic [BW-1:0] bytes_o
);
  logic busy_q, busy_d, inf_q, inf_d, done_q, done_d;
  logic aad_phase, take, final_blk;

  always_comb begin
    aad_phase = !aad_zero_i;
    take      = busy_q && blk_req_i && !load_i;
    final_blk = busy_q && !inf_q &&
                (aad_phase ? (aad_last_i && pay_zero_i) : pay_last_i);
    busy_d = busy_q;
    if (load_i)                 busy_d = 1'b1;
    else if (take && final_blk) busy_d = 1'b0;
    inf_d  = load_i ? load_inf_i : inf_q;
    done_d = take && final_blk;
    aad_step_o = take && aad_phase;
    pay_step_o = take && !aad_phase && !inf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      inf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      inf_q  <= inf_d;
      done_q <= done_d;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign last_o   = final_blk;
  assign is_aad_o = busy_q && aad_phase;
  assign bytes_o  = !busy_q   ? '0 :
                    aad_phase ? aad_bytes_i :
                    inf_q     ? BW'(BLK) : pay_bytes_i;
endmodule

// File: rtl/crypto_len_tracker.sv
module crypto_len_tracker
  import crypto_len_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int HI_KEEP = 29,
  parameter int IDX_LSB = 4,
  parameter int BLK     = 16,
  localparam int PAY_W  = WORD_W + HI_KEEP,
  localparam int IDX_W  = WORD_W - IDX_LSB,
  localparam int BW     = $clog2(BLK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [1:0]        mode_i,
  input  logic              blk_req_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              start_o,
  output logic              busy_o,
  output logic [BW-1:0]     blk_bytes_o,
  output logic              blk_is_aad_o,
  output logic              last_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  xts_index_o
);
  cl_mode_e          job_mode;
  logic [PAY_W-1:0]  pay_len;
  logic [WORD_W-1:0] aad_len, aad_load;
  logic              load_inf;
  logic              aad_step, pay_step;
  logic              aad_zero, aad_last, pay_zero, pay_last;
  logic [BW-1:0]     aad_bytes, pay_bytes;

  cl_host_regs #(.WORD_W(WORD_W), .HI_KEEP(HI_KEEP), .IDX_LSB(IDX_LSB)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (cl_sel_e'(wr_sel_i)),
    .wr_data_i (wr_data_i),
    .mode_i    (cl_mode_e'(mode_i)),
    .start_o   (start_o),
    .mode_o    (job_mode),
    .pay_len_o (pay_len),
    .aad_len_o (aad_len),
    .xts_idx_o (xts_index_o)
  );

  assign aad_load = (job_mode == MODE_AEAD) ? aad_len : '0;
  assign load_inf = (job_mode == MODE_STREAM) && (pay_len == '0);

  cl_blk_counter #(.W(WORD_W), .BLK(BLK)) i_aad_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(start_o), .load_val_i(aad_load),
    .step_i(aad_step), .zero_o(aad_zero), .last_o(aad_last), .bytes_o(aad_bytes)
  );

  cl_blk_counter #(.W(PAY_W), .BLK(BLK)) i_pay_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(start_o), .load_val_i(pay_len),
    .step_i(pay_step), .zero_o(pay_zero), .last_o(pay_last), .bytes_o(pay_bytes)
  );

  cl_job_seq #(.BLK(BLK)) i_seq (
    .clk(clk), .rst_n(rst_n), .load_i(start_o), .load_inf_i(load_inf),
    .blk_req_i(blk_req_i),
    .aad_zero_i(aad_zero), .aad_last_i(aad_last), .aad_bytes_i(aad_bytes),
    .pay_zero_i(pay_zero), .pay_last_i(pay_last), .pay_bytes_i(pay_bytes),
    .aad_step_o(aad_step), .pay_step_o(pay_step),
    .busy_o(busy_o), .done_o(done_o), .last_o(last_o),
    .is_aad_o(blk_is_aad_o), .bytes_o(blk_bytes_o)
  );

  assign rd_data_o = '0;
endmodule

// File: rtl/crypto_len_tracker_chk.sv
module crypto_len_tracker_chk #(
  parameter int BLK = 16,
  localparam int BW = $clog2(BLK + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en_i,
  input logic [1:0]    wr_sel_i,
  input logic [1:0]    mode_i,
  input logic          start_o,
  input logic          busy_o,
  input logic [BW-1:0] blk_bytes_o,
  input logic          last_o,
  input logic          done_o
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_o);

  assert_lo_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd0) |=> !start_o);

  assert_aead_hi_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd1 && mode_i == 2'd1) |=> !start_o);

  assert_bytes_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (blk_bytes_o != '0 && blk_bytes_o <= BW'(BLK)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (!busy_o && $past(busy_o)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (blk_bytes_o == '0 && !last_o));
endmodule

bind crypto_len_tracker crypto_len_tracker_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .mode_i(mode_i), .start_o(start_o), .busy_o(busy_o),
  .blk_bytes_o(blk_bytes_o), .last_o(last_o), .done_o(done_o)
);

// File: tb/test_crypto_len_tracker.sv
module test_crypto_len_tracker;
  logic        clk;
  logic        rst_n;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [31:0] wr_data_i;
  logic [1:0]  mode_i;
  logic        blk_req_i;
  logic [31:0] rd_data_o;
  logic        start_o, busy_o, blk_is_aad_o, last_o, done_o;
  logic [4:0]  blk_bytes_o;
  logic [27:0] xts_index_o;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [1:0] STREAM = 2'd0, AEAD = 2'd1, XTS = 2'd2, FIXED = 2'd3;

  crypto_len_tracker i_crypto_len_tracker (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .mode_i(mode_i), .blk_req_i(blk_req_i),
    .rd_data_o(rd_data_o), .start_o(start_o), .busy_o(busy_o),
    .blk_bytes_o(blk_bytes_o), .blk_is_aad_o(blk_is_aad_o),
    .last_o(last_o), .done_o(done_o), .xts_index_o(xts_index_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en_i = 1'b0; wr_sel_i = 2'd3; wr_data_i = '0;
    mode_i = STREAM; blk_req_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // write one word; returns at the negedge where start_o reflects it
  task automatic host_wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0; wr_sel_i = 2'd3;
  endtask

  // call at the negedge where start_o is high
  task automatic run_job(input string req, input longint aad, input longint pay);
    longint a = aad;
    longint p = pay;
    longint b;
    logic   is_a;
    check({req, " start"}, start_o, 1);
    @(negedge clk);
    check({req, " busy"}, busy_o, 1);
    while (a + p > 0) begin
      is_a = (a > 0);
      b = is_a ? ((a > 16) ? 16 : a) : ((p > 16) ? 16 : p);
      if (is_a) a -= b; else p -= b;
      check({req, " bytes"}, blk_bytes_o, b);
      check({req, " is_aad"}, blk_is_aad_o, is_a);
      check({req, " last"}, last_o, (a + p == 0));
      blk_req_i = 1'b1;
      @(negedge clk);
      blk_req_i = 1'b0;
    end
    check({req, " R6 done"}, done_o, 1);
    check({req, " R6 busy low"}, busy_o, 0);
    @(negedge clk);
    check({req, " R6 done one cycle"}, done_o, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 start", start_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 last", last_o, 0);
    check("R1 aad", blk_is_aad_o, 0);
    check("R1 bytes", blk_bytes_o, 0);
  endtask

  task automatic t_fixed();
    mode_i = FIXED;
    host_wr(2'd0, 32'd40);
    check("R2 lo no start", start_o, 0);
    host_wr(2'd1, 32'd0);
    run_job("R2 R5 fixed 40", 0, 40);
  endtask

  task automatic t_hi_mask();
    mode_i = FIXED;
    host_wr(2'd0, 32'd32);
    host_wr(2'd1, 32'hE000_0000);
    run_job("R3 hi mask", 0, 32);
  endtask

  task automatic t_aead();
    mode_i = AEAD;
    host_wr(2'd0, 32'd20);
    host_wr(2'd1, 32'd0);
    check("R4 hi no start", start_o, 0);
    host_wr(2'd2, 32'd5);
    run_job("R4 R5 aead", 5, 20);
  endtask

  task automatic t_aead_zero();
    mode_i = AEAD;
    host_wr(2'd0, 32'd0);
    host_wr(2'd1, 32'd0);
    host_wr(2'd2, 32'd33);
    run_job("R8 aead pay zero", 33, 0);
    host_wr(2'd2, 32'd0);
    check("R8 aead both zero", start_o, 0);
    @(negedge clk);
    check("R8 aead both zero busy", busy_o, 0);
  endtask

  task automatic t_fixed_zero();
    mode_i = FIXED;
    host_wr(2'd0, 32'd0);
    host_wr(2'd1, 32'd0);
    check("R8 fixed zero", start_o, 0);
    mode_i = XTS;
    host_wr(2'd1, 32'd0);
    check("R8 xts zero", start_o, 0);
  endtask

  task automatic t_stream_inf();
    mode_i = STREAM;
    host_wr(2'd0, 32'd0);
    host_wr(2'd1, 32'd0);
    check("R7 start", start_o, 1);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check("R7 bytes", blk_bytes_o, 16);
      check("R7 last", last_o, 0);
      check("R7 busy", busy_o, 1);
      blk_req_i = 1'b1;
      @(negedge clk);
      blk_req_i = 1'b0;
      check("R7 done", done_o, 0);
    end
    do_reset();
  endtask

  task automatic t_stream_exact();
    mode_i = STREAM;
    host_wr(2'd0, 32'd16);
    host_wr(2'd1, 32'd0);
    run_job("R5 stream 16", 0, 16);
  endtask

  task automatic t_xts();
    mode_i = XTS;
    host_wr(2'd2, 32'h1234_5678);
    check("R9 no start", start_o, 0);
    check("R9 index", xts_index_o, 28'h123_4567);
    host_wr(2'd0, 32'd17);
    host_wr(2'd1, 32'd0);
    run_job("R9 xts job", 0, 17);
  endtask

  task automatic t_idle();
    @(negedge clk);
    blk_req_i = 1'b1;
    repeat (3) @(negedge clk);
    blk_req_i = 1'b0;
    check("R11 busy", busy_o, 0);
    check("R11 done", done_o, 0);
    check("R11 last", last_o, 0);
    check("R11 bytes", blk_bytes_o, 0);
    check("R10 read zero", rd_data_o, 0);
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_hi_mask();
    t_aead();
    t_aead_zero();
    t_fixed_zero();
    t_idle();
    t_stream_inf();
    t_stream_exact();
    t_xts();
    check("R10 read zero end", rd_data_o, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule